// File: doc/BRIEF.md
# Associative Named-Variable Operand Cache

This block stands in for a register file: it keeps the values of named scalar variables that are in current use in a small, fully associative store. Each request carries a base register value, a name offset and an operand size of 32 or 64 bits. The block forms the operand address from these three inputs. It searches its 32 entries for the 64-bit word that holds the operand. A read returns the operand and a write updates the entry.

The work is split into three pipeline stages: address formation, associative match and value read/write. A new lookup can therefore enter while the previous one is still reading its value. When a lookup misses, the match stage holds and the requester is stalled. A simple backing-store port then fetches the 64-bit word into the entry chosen by a rotating pointer. If that entry holds modified data, the block first writes the data back.

Top module: `name_operand_cache`

## Requirements
- R1: The operand address is `{req_base[ADDR_W-1:1],0} + name`, modulo 2^ADDR_W. Here `name` is `req_name` for a 32-bit operand and `req_name` shifted left by one for a 64-bit operand. Bit 0 of the base never affects the result.
- R2: For a 32-bit read, address bit 0 picks the half of the 64-bit entry: 0 picks bits [31:0] and 1 picks bits [63:32]. The half is returned in `rsp_data[31:0]`, with `rsp_data[63:32]` zero.
- R3: A 64-bit read returns the whole 64-bit entry on `rsp_data`.
- R4: A lookup that misses issues one backing-store read (`mem_req_write`=0) with its address bit 0 cleared. `req_ready` stays low from the cycle the miss reaches the match stage until the fill lands. A request that is not accepted holds its address until it is.
- R5: After a fill, any access to either half of that 64-bit word hits, with no further backing-store request.
- R6: A 32-bit write replaces only the addressed half (`req_wdata[31:0]`) and keeps the other half. A 64-bit write replaces the whole entry. Writes produce no response.
- R7: Fills go to entries in rotating order 0,1,…,31,0,… The 33rd distinct word evicts the first one filled, and the second one filled stays resident until the 34th fill.
- R8: Evicting an entry that was written since its fill first issues a backing-store write (`mem_req_write`=1) of that entry's address and data, and then issues the fill read. Evicting an unmodified entry issues no write.
- R9: Hits are accepted on consecutive cycles. A read that hits presents `rsp_valid` on the third clock edge after the edge that accepted it.
- R10: After reset, `req_ready` is high, `rsp_valid` and `mem_req_valid` are low, and no entry is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size64 | input | 1 | 1 = 64-bit operand, 0 = 32-bit |
| req_base | input | ADDR_W | Selected base register value |
| req_name | input | NAME_W | Name offset from the instruction |
| req_wdata | input | 64 | Write data (low half used for 32-bit) |
| rsp_valid | output | 1 | Read result present |
| rsp_data | output | 64 | Read result |
| mem_req_valid | output | 1 | Backing-store request |
| mem_req_ready | input | 1 | Backing store takes the request |
| mem_req_write | output | 1 | 1 = writeback, 0 = fill read |
| mem_req_addr | output | ADDR_W | 64-bit-aligned word address |
| mem_req_wdata | output | 64 | Writeback data |
| mem_rsp_valid | input | 1 | Fill data present |
| mem_rsp_data | input | 64 | Fill data |

## Verification
Two things can coincide in one cycle. A write can commit into the value array in the read stage while the next access to the same entry is being matched, and that access then reads the entry on the following cycle. The bench provokes this with back-to-back writes and reads of both halves of one word. It judges the case by the merged values returned, and by responses arriving on their fixed latency. The other overlap is an eviction choosing a victim that was modified just before. Filling the cache past capacity after writing the first entry makes this happen, and the order, address and data of the backing-store requests are compared.

// File: rtl/nsc_pkg.sv
package nsc_pkg;
  localparam int unsigned HALF_W = 32;
  localparam int unsigned LINE_W = 2 * HALF_W;

  typedef enum logic [1:0] {
    MS_IDLE,
    MS_EVICT,
    MS_FILL_REQ,
    MS_FILL_WAIT
  } miss_state_e;

  // Replace one half of a line, keep the other
  function automatic logic [LINE_W-1:0] merge_half(input logic [LINE_W-1:0] line,
                                                   input logic [HALF_W-1:0] word,
                                                   input logic              hi);
    logic [LINE_W-1:0] res;
    res = line;
    if (hi) res[LINE_W-1:HALF_W] = word;
    else    res[HALF_W-1:0]      = word;
    return res;
  endfunction
endpackage

// File: rtl/nsc_addr_form.sv
module nsc_addr_form #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned NAME_W = 16
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [NAME_W-1:0] name,
  input  logic              size64,
  output logic [ADDR_W-1:0] addr
);
  logic [ADDR_W-1:0] base_al;
  logic [ADDR_W-1:0] name_ext;
  logic [ADDR_W-1:0] name_sc;

  always_comb begin
    base_al  = {base[ADDR_W-1:1], 1'b0};
    name_ext = ADDR_W'(name);
    name_sc  = size64 ? {name_ext[ADDR_W-2:0], 1'b0} : name_ext;
    addr     = base_al + name_sc;
  end
endmodule

// File: rtl/nsc_tag_array.sv
module nsc_tag_array #(
  parameter int unsigned ENTRIES = 32,
  parameter int unsigned TAG_W   = 15,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TAG_W-1:0] lookup_tag,
  output logic             hit,
  output logic [IDX_W-1:0] hit_idx,
  input  logic [IDX_W-1:0] victim_idx,
  output logic             victim_valid,
  output logic [TAG_W-1:0] victim_tag,
  input  logic             fill_we,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [TAG_W-1:0] fill_tag
);
  logic [ENTRIES-1:0] valid_q, valid_d;
  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic [ENTRIES-1:0] match_vec;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
    assign match_vec[e] = valid_q[e] && (tag_q[e] == lookup_tag);
  end

  always_comb begin
    hit_idx = '0;
    for (int e = 0; e < ENTRIES; e++)
      if (match_vec[e]) hit_idx = hit_idx | IDX_W'(e);
    hit = |match_vec;
  end

  assign victim_valid = valid_q[victim_idx];
  assign victim_tag   = tag_q[victim_idx];

  always_comb begin
    valid_d = valid_q;
    if (fill_we) valid_d[fill_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (fill_we) tag_q[fill_idx] <= fill_tag;
  end

  // R5: a word is never resident twice
  a_r5_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match_vec));
endmodule

// File: rtl/nsc_value_ram.sv
module nsc_value_ram #(
  parameter int unsigned ENTRIES = 32,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [63:0]      rd_data,
  input  logic [IDX_W-1:0] vic_idx,
  output logic [63:0]      vic_data,
  output logic             vic_dirty,
  input  logic             fill_we,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [63:0]      fill_data,
  input  logic             st_we,
  input  logic             st_size64,
  input  logic             st_hi,
  input  logic [63:0]      st_data
);
  import nsc_pkg::*;

  logic [63:0]        data_q [ENTRIES];
  logic [ENTRIES-1:0] dirty_q, dirty_d;
  logic [63:0]        st_line;

  assign rd_data   = data_q[rd_idx];
  assign vic_data  = data_q[vic_idx];
  assign vic_dirty = dirty_q[vic_idx];

  always_comb begin
    st_line = st_size64 ? st_data : merge_half(data_q[rd_idx], st_data[HALF_W-1:0], st_hi);
    dirty_d = dirty_q;
    if (fill_we)    dirty_d[fill_idx] = 1'b0;
    else if (st_we) dirty_d[rd_idx]   = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dirty_q <= '0;
    else        dirty_q <= dirty_d;
  end

  always_ff @(posedge clk) begin
    if (fill_we)    data_q[fill_idx] <= fill_data;
    else if (st_we) data_q[rd_idx]   <= st_line;
  end

  // R6: a store never meets a fill in the same cycle
  a_r6_no_port_clash: assert property (@(posedge clk) disable iff (!rst_n)
    !(fill_we && st_we));
endmodule

// File: rtl/nsc_miss_ctrl.sv
module nsc_miss_ctrl #(
  parameter int unsigned ENTRIES = 32,
  parameter int unsigned ADDR_W  = 16,
  localparam int unsigned IDX_W  = $clog2(ENTRIES),
  localparam int unsigned TAG_W  = ADDR_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              miss,
  input  logic [TAG_W-1:0]  miss_tag,
  output logic [IDX_W-1:0]  victim_idx,
  input  logic              vic_valid,
  input  logic              vic_dirty,
  input  logic [TAG_W-1:0]  vic_tag,
  input  logic [63:0]       vic_data,
  output logic              busy,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [63:0]       mem_req_wdata,
  input  logic              mem_rsp_valid,
  output logic              fill_we
);
  import nsc_pkg::*;

  miss_state_e      state_q, state_d;
  logic [IDX_W-1:0] rr_q, rr_d;

  always_comb begin
    state_d       = state_q;
    rr_d          = rr_q;
    mem_req_valid = 1'b0;
    mem_req_write = 1'b0;
    mem_req_addr  = '0;
    mem_req_wdata = '0;
    fill_we       = 1'b0;
    unique case (state_q)
      MS_IDLE: if (miss) state_d = MS_EVICT;
      MS_EVICT: begin
        if (vic_valid && vic_dirty) begin
          mem_req_valid = 1'b1;
          mem_req_write = 1'b1;
          mem_req_addr  = {vic_tag, 1'b0};
          mem_req_wdata = vic_data;
          if (mem_req_ready) state_d = MS_FILL_REQ;
        end else begin
          state_d = MS_FILL_REQ;
        end
      end
      MS_FILL_REQ: begin
        mem_req_valid = 1'b1;
        mem_req_addr  = {miss_tag, 1'b0};
        if (mem_req_ready) state_d = MS_FILL_WAIT;
      end
      MS_FILL_WAIT: begin
        if (mem_rsp_valid) begin
          fill_we = 1'b1;
          state_d = MS_IDLE;
          rr_d    = (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
        end
      end
      default: state_d = MS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= MS_IDLE;
      rr_q    <= '0;
    end else begin
      state_q <= state_d;
      rr_q    <= rr_d;
    end
  end

  assign victim_idx = rr_q;
  assign busy       = (state_q != MS_IDLE);

  // R8: a taken writeback is followed at once by the fill read
  a_r8_fill_after_wb: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_write && mem_req_ready) |=> (mem_req_valid && !mem_req_write));
  // R4: a pending request holds its address and kind
  a_r4_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)));
  // R7: every fill moves the replacement pointer on
  a_r7_rr_step: assert property (@(posedge clk) disable iff (!rst_n)
    fill_we |=> (victim_idx != $past(victim_idx)));
endmodule

// File: rtl/name_operand_cache.sv
module name_operand_cache #(
  parameter int unsigned ENTRIES = 32,
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned NAME_W  = 16,
  localparam int unsigned IDX_W  = $clog2(ENTRIES),
  localparam int unsigned TAG_W  = ADDR_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_size64,
  input  logic [ADDR_W-1:0] req_base,
  input  logic [NAME_W-1:0] req_name,
  input  logic [63:0]       req_wdata,
  output logic              rsp_valid,
  output logic [63:0]       rsp_data,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [63:0]       mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [63:0]       mem_rsp_data
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  // stage 1: formed address
  logic              s1_valid_q, s1_valid_d;
  logic [TAG_W-1:0]  s1_tag_q;
  logic              s1_half_q, s1_size64_q, s1_write_q;
  logic [63:0]       s1_wdata_q;
  // stage 2: associative match
  logic              s2_valid_q, s2_valid_d;
  logic [TAG_W-1:0]  s2_tag_q;
  logic              s2_half_q, s2_size64_q, s2_write_q;
  logic [63:0]       s2_wdata_q;
  // stage 3: value read / write
  logic              s3_valid_q, s3_valid_d;
  logic [IDX_W-1:0]  s3_idx_q;
  logic              s3_half_q, s3_size64_q, s3_write_q;
  logic [63:0]       s3_wdata_q;
  // response
  logic              rsp_valid_d;
  logic [63:0]       rsp_data_d;

  logic [ADDR_W-1:0] op_addr;
  logic              hit, miss, advance, accept, miss_busy, fill_we, st_we;
  logic [IDX_W-1:0]  hit_idx, victim_idx;
  logic              vic_valid, vic_dirty;
  logic [TAG_W-1:0]  vic_tag;
  logic [63:0]       vic_data, rd_data;

  nsc_addr_form #(.ADDR_W(ADDR_W), .NAME_W(NAME_W)) u_addr (
    .base(req_base), .name(req_name), .size64(req_size64), .addr(op_addr)
  );

  nsc_tag_array #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst_n(rst_i_n), .lookup_tag(s2_tag_q), .hit(hit), .hit_idx(hit_idx),
    .victim_idx(victim_idx), .victim_valid(vic_valid), .victim_tag(vic_tag),
    .fill_we(fill_we), .fill_idx(victim_idx), .fill_tag(s2_tag_q)
  );

  nsc_value_ram #(.ENTRIES(ENTRIES)) u_vals (
    .clk(clk), .rst_n(rst_i_n), .rd_idx(s3_idx_q), .rd_data(rd_data),
    .vic_idx(victim_idx), .vic_data(vic_data), .vic_dirty(vic_dirty),
    .fill_we(fill_we), .fill_idx(victim_idx), .fill_data(mem_rsp_data),
    .st_we(st_we), .st_size64(s3_size64_q), .st_hi(s3_half_q), .st_data(s3_wdata_q)
  );

  nsc_miss_ctrl #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_miss (
    .clk(clk), .rst_n(rst_i_n), .miss(miss), .miss_tag(s2_tag_q),
    .victim_idx(victim_idx), .vic_valid(vic_valid), .vic_dirty(vic_dirty),
    .vic_tag(vic_tag), .vic_data(vic_data), .busy(miss_busy),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid), .fill_we(fill_we)
  );

  // next state
  always_comb begin
    miss        = s2_valid_q && !hit;
    advance     = !miss;
    req_ready   = advance && rst_i_n;
    accept      = req_valid && req_ready;
    s1_valid_d  = advance ? accept : s1_valid_q;
    s2_valid_d  = advance ? s1_valid_q : s2_valid_q;
    s3_valid_d  = s2_valid_q && hit;
    st_we       = s3_valid_q && s3_write_q;
    rsp_valid_d = s3_valid_q && !s3_write_q;
    if (s3_size64_q)    rsp_data_d = rd_data;
    else if (s3_half_q) rsp_data_d = {32'b0, rd_data[63:32]};
    else                rsp_data_d = {32'b0, rd_data[31:0]};
  end

  // control registers
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      s1_valid_q <= 1'b0;
      s2_valid_q <= 1'b0;
      s3_valid_q <= 1'b0;
      rsp_valid  <= 1'b0;
    end else begin
      s1_valid_q <= s1_valid_d;
      s2_valid_q <= s2_valid_d;
      s3_valid_q <= s3_valid_d;
      rsp_valid  <= rsp_valid_d;
    end
  end

  // data registers with explicit enables
  always_ff @(posedge clk) begin
    if (accept) begin
      s1_tag_q    <= op_addr[ADDR_W-1:1];
      s1_half_q   <= op_addr[0];
      s1_size64_q <= req_size64;
      s1_write_q  <= req_write;
      s1_wdata_q  <= req_wdata;
    end
    if (advance) begin
      s2_tag_q    <= s1_tag_q;
      s2_half_q   <= s1_half_q;
      s2_size64_q <= s1_size64_q;
      s2_write_q  <= s1_write_q;
      s2_wdata_q  <= s1_wdata_q;
    end
    if (s3_valid_d) begin
      s3_idx_q    <= hit_idx;
      s3_half_q   <= s2_half_q;
      s3_size64_q <= s2_size64_q;
      s3_write_q  <= s2_write_q;
      s3_wdata_q  <= s2_wdata_q;
    end
    if (rsp_valid_d) rsp_data <= rsp_data_d;
  end

  // R4: no request enters while a miss is being serviced
  a_r4_hold_while_busy: assert property (@(posedge clk) disable iff (!rst_i_n)
    miss_busy |-> !req_ready);
  // R9: a response is always preceded by a read in the value stage
  a_r9_rsp_from_read: assert property (@(posedge clk) disable iff (!rst_i_n)
    $rose(rsp_valid) |-> $past(s3_valid_q));
endmodule

// File: tb/name_operand_cache_tb_top.sv
module name_operand_cache_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_size64 = 1'b0;
  logic [15:0] req_base = '0, req_name = '0;
  logic [63:0] req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic [63:0] rsp_data;
  logic        mem_req_valid, mem_req_write;
  logic        mem_req_ready = 1'b0;
  logic [15:0] mem_req_addr;
  logic [63:0] mem_req_wdata;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;

  always #2.5 clk = ~clk;

  name_operand_cache dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_size64(req_size64), .req_base(req_base),
    .req_name(req_name), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data)
  );

  int n_cmp = 0, n_bad = 0, cyc = 0, last_acc = 0;
  bit chk_lat = 0, done = 0;

  typedef struct packed { logic [63:0] d; int c; bit lat; } exp_t;
  typedef struct packed { logic w; logic [15:0] a; logic [63:0] d; } mlog_t;
  exp_t        expq[$];
  mlog_t       mlog[$];
  logic [63:0] refm [int];
  logic [63:0] bmem [int];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [63:0] pat(input logic [14:0] t);
    return {17'h1B5A3, t, 17'h0C3F1 ^ 17'(t), t};
  endfunction

  function automatic logic [63:0] model_get(input logic [14:0] t);
    return refm.exists(int'(t)) ? refm[int'(t)] : pat(t);
  endfunction

  task automatic check(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // driver: called at a falling edge, returns at the falling edge after acceptance
  task automatic issue(input bit w, input bit s64, input logic [15:0] b,
                       input logic [15:0] nm, input logic [63:0] wd);
    logic [15:0] a;
    logic [14:0] t;
    logic [63:0] cur;
    exp_t        e;
    a = {b[15:1], 1'b0} + (s64 ? {nm[14:0], 1'b0} : nm);   // R1 formula
    t = a[15:1];
    req_valid = 1; req_write = w; req_size64 = s64; req_base = b; req_name = nm; req_wdata = wd;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    last_acc = cyc;
    req_valid = 0;
    cur = model_get(t);
    if (w) begin
      if (s64)       refm[int'(t)] = wd;
      else if (a[0]) refm[int'(t)] = {wd[31:0], cur[31:0]};
      else           refm[int'(t)] = {cur[63:32], wd[31:0]};
    end else begin
      e.d   = s64 ? cur : (a[0] ? {32'b0, cur[63:32]} : {32'b0, cur[31:0]});
      e.c   = cyc + 3;
      e.lat = chk_lat;
      expq.push_back(e);
    end
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (expq.size() != 0 || !req_ready || mem_req_valid || dut_busy_ext()) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  // backing-store stub
  bit          pend = 0;
  int          pend_cnt = 0;
  logic [14:0] pend_tag = '0;
  function automatic bit dut_busy_ext();
    return pend || mem_rsp_valid;
  endfunction

  always @(negedge clk) begin
    mlog_t m;
    mem_rsp_valid = 1'b0;
    if (pend) begin
      if (pend_cnt == 0) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = bmem.exists(int'(pend_tag)) ? bmem[int'(pend_tag)] : pat(pend_tag);
        pend = 0;
      end else pend_cnt--;
    end
    mem_req_ready = (cyc % 3) != 1;
    if (rst_n && mem_req_valid && mem_req_ready) begin
      m.w = mem_req_write; m.a = mem_req_addr; m.d = mem_req_wdata;
      mlog.push_back(m);
      if (mem_req_write) bmem[int'(mem_req_addr[15:1])] = mem_req_wdata;
      else begin pend = 1; pend_cnt = 2; pend_tag = mem_req_addr[15:1]; end
    end
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    exp_t e;
    if (rst_n && rsp_valid === 1'b1) begin
      if (expq.size() == 0) check(0, "R3 unexpected response", rsp_data, '0);
      else begin
        e = expq.pop_front();
        check(rsp_data === e.d, "R2/R3 read data", rsp_data, e.d);
        if (e.lat) check(cyc == e.c, "R9 hit latency", 64'(cyc), 64'(e.c));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    int n0, a1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R10 reset state
    check(req_ready === 1'b1, "R10 req_ready", 64'(req_ready), 64'd1);
    check(rsp_valid === 1'b0, "R10 rsp_valid", 64'(rsp_valid), 64'd0);
    check(mem_req_valid === 1'b0, "R10 mem_req_valid", 64'(mem_req_valid), 64'd0);

    // R1 R4 first access misses; base bit 0 ignored, 64-bit name shifted
    issue(0, 1, 16'h0101, 16'd3, '0);
    @(negedge clk);
    check(req_ready === 1'b0, "R4 stall on miss", 64'(req_ready), 64'd0);
    wait_idle();
    check(mlog.size() == 1, "R4 one fill request", 64'(mlog.size()), 64'd1);
    check(mlog[0].w == 1'b0 && mlog[0].a == 16'h0106, "R1 fill address", 64'(mlog[0].a), 64'h0106);

    // R2 R5 R9 back-to-back hits on both halves
    chk_lat = 1;
    n0 = mlog.size();
    issue(0, 0, 16'h0100, 16'd6, '0);
    a1 = last_acc;
    issue(0, 0, 16'h0100, 16'd7, '0);
    check(last_acc == a1 + 1, "R9 consecutive accept", 64'(last_acc), 64'(a1 + 1));
    issue(0, 1, 16'h0000, 16'h0083, '0);
    check(last_acc == a1 + 2, "R9 consecutive accept", 64'(last_acc), 64'(a1 + 2));

    // R6 writes merged and replaced, read back immediately
    issue(1, 1, 16'h0100, 16'd3, 64'h0123_4567_89AB_CDEF);
    issue(1, 0, 16'h0100, 16'd7, 64'h0000_0000_1234_5678);
    issue(0, 1, 16'h0100, 16'd3, '0);
    issue(1, 0, 16'h0100, 16'd6, 64'hFFFF_FFFF_CAFE_F00D);
    issue(0, 0, 16'h0100, 16'd7, '0);
    issue(0, 1, 16'h0100, 16'd3, '0);
    wait_idle();
    check(mlog.size() == n0, "R5 no request on hits", 64'(mlog.size()), 64'(n0));
    chk_lat = 0;

    // R7 R8 fill the rest, then overflow
    for (int i = 1; i < 32; i++) issue(0, 1, 16'h0200, 16'(i), '0);
    wait_idle();
    n0 = mlog.size();
    issue(0, 1, 16'h0200, 16'd32, '0);
    wait_idle();
    check(mlog.size() == n0 + 2, "R8 writeback then fill", 64'(mlog.size()), 64'(n0 + 2));
    check(mlog[n0].w == 1'b1 && mlog[n0].a == 16'h0106, "R8 writeback addr", 64'(mlog[n0].a), 64'h0106);
    check(mlog[n0].d == 64'h1234_5678_CAFE_F00D, "R8 writeback data", mlog[n0].d, 64'h1234_5678_CAFE_F00D);
    check(mlog[n0+1].w == 1'b0 && mlog[n0+1].a == 16'h0240, "R8 fill after writeback", 64'(mlog[n0+1].a), 64'h0240);
    n0 = mlog.size();
    issue(0, 1, 16'h0200, 16'd1, '0);
    wait_idle();
    check(mlog.size() == n0, "R7 second fill still resident", 64'(mlog.size()), 64'(n0));
    issue(0, 1, 16'h0100, 16'd3, '0);
    wait_idle();
    check(mlog.size() == n0 + 1, "R8 clean eviction silent", 64'(mlog.size()), 64'(n0 + 1));
    check(mlog[n0].w == 1'b0 && mlog[n0].a == 16'h0106, "R8 refill address", 64'(mlog[n0].a), 64'h0106);
    issue(0, 1, 16'h0200, 16'd1, '0);
    wait_idle();
    check(mlog.size() == n0 + 2, "R7 rotating victim", 64'(mlog.size()), 64'(n0 + 2));
    check(mlog[n0+1].a == 16'h0202, "R7 refill of second entry", 64'(mlog[n0+1].a), 64'h0202);
    summary();
  end
endmodule